// File: doc/BRIEF.md
# UART Transmitter with Holding Buffer and Status Flags

This block is the transmit half of an asynchronous serial port. Software writes a character into a one-entry holding buffer. As soon as the frame shifter is free, or at the very moment it finishes the last stop bit of the frame in progress, the character moves into the shifter. That gives back-to-back frames with no idle gap between them. Each frame has a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high. Bit timing comes from an external one-cycle baud tick, and each bit lasts 16 ticks.

Two status flags tell software how the transmitter stands. The buffer-empty flag shows that a new character can be written. The all-done flag shows that the line has gone quiet with nothing left to send. Each flag drives an interrupt request through its own enable. Software clears a flag by writing zero to it, and a write of one leaves it unchanged. The done flag also clears when its interrupt is acknowledged. Dropping the enable input stops everything at once: the frame in progress is cut off and the buffer is discarded.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After a synchronous reset, txd is 1, empty_flag is 1, done_flag is 0, and both interrupt requests are 0.
- R2: A frame is a start bit of 0, then cfg_nbits data bits (valid values 5 to 9) least significant bit first, then the parity bit when cfg_par_en is 1, then one stop bit of 1, or two stop bits when cfg_two_stop is 1. The line is 1 between frames.
- R3: The parity bit is the XOR of the cfg_nbits data bits that are sent. It is inverted when cfg_par_odd is 1.
- R4: Data bit 8 (the ninth bit) is the value of tx_bit8 in the cycle where wr_data is 1. Later changes to tx_bit8 do not alter that character.
- R5: Each bit lasts exactly 16 baud ticks. The bit timer advances only in cycles where baud_tick is 1.
- R6: When the buffer holds a character as the final stop bit ends, the next start bit begins in the following cycle. Consecutive start bits are therefore exactly 16 times the frame length in ticks apart.
- R7: empty_flag becomes 0 in the cycle after a write. It becomes 1 in the cycle after the character moves into the shifter.
- R8: Writing 0 to a flag through st_wr clears that flag. Writing 1 leaves it unchanged.
- R9: done_flag becomes 1 only when a frame's final stop bit ends and no character is waiting. It stays 0 between back-to-back frames.
- R10: A pulse on done_ack clears done_flag.
- R11: irq_empty equals empty_flag AND ie_empty, and irq_done equals done_flag AND ie_done.
- R12: While tx_en is 0, txd is 1, the buffer is empty, empty_flag is 1, and writes are ignored. Clearing tx_en in the middle of a frame aborts that frame, and the discarded character is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle oversample tick |
| tx_en | input | 1 | Transmitter enable |
| cfg_nbits | input | 4 | Data bits per character, 5 to 9 |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_bit8 | input | 1 | Ninth data bit, captured with the write |
| wr_data | input | 1 | Write strobe for the holding buffer |
| wr_byte | input | 8 | Data bits 7..0 of the character |
| st_wr | input | 1 | Status write strobe |
| st_empty_val | input | 1 | Value written to the empty flag (only 0 takes effect) |
| st_done_val | input | 1 | Value written to the done flag (only 0 takes effect) |
| done_ack | input | 1 | Acknowledge of the done interrupt |
| ie_empty | input | 1 | Empty interrupt enable |
| ie_done | input | 1 | Done interrupt enable |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding buffer empty flag |
| done_flag | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
The frame format is swept over every data length from 5 to 9, with no parity, even parity and odd parity, and with one and two stop bits, using two data patterns each. A wrong bit order, a wrong parity sense or a wrong stop count shows up in a different part of the decoded word. A nine-bit character whose control bit is flipped right after the write tells capture-at-write apart from sampling at load time. A run with a tick every third cycle checks that the bit timer follows the tick and not the clock. Two characters written while the shifter is busy separate a gapless refill from one that idles in between, and they also show that the done flag stays low across the join. An abort with a character still waiting checks that the buffer is dropped rather than sent later.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP1 = 3'd4,
    PH_STOP2 = 3'd5
  } phase_t;
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic [DW-1:0] wr_word,
  input  logic          take,
  input  logic          st_wr,
  input  logic          st_val,
  output logic          full,
  output logic [DW-1:0] word,
  output logic          empty_flag
);
  always_ff @(posedge clk) begin
    if (rst || !en) full <= 1'b0;
    else if (wr)    full <= 1'b1;
    else if (take)  full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (en && wr) word <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)             empty_flag <= 1'b1;
    else if (wr)                empty_flag <= 1'b0;
    else if (take)              empty_flag <= 1'b1;
    else if (st_wr && !st_val)  empty_flag <= 1'b0;
  end

  // R7
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr) |=> !empty_flag);
  // R7
  take_sets_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (en && take && !wr) |=> empty_flag);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DMAX = 9,
  parameter int OS   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       tick,
  input  logic                       load,
  input  logic [DMAX-1:0]            ld_word,
  input  logic [$clog2(DMAX+1)-1:0]  nbits,
  input  logic                       par_en,
  input  logic                       par_odd,
  input  logic                       two_stop,
  output logic                       txd,
  output logic                       busy,
  output logic                       frame_end
);
  localparam int OSW = $clog2(OS);
  localparam int IW  = $clog2(DMAX);

  phase_t          phase;
  logic [OSW-1:0]  os_cnt;
  logic [IW-1:0]   bit_idx;
  logic [DMAX-1:0] sh;
  logic            par_bit;
  logic [DMAX-1:0] mask;
  logic            bit_end;
  logic            last_data;

  always_comb begin
    for (int i = 0; i < DMAX; i++) mask[i] = (i < int'(nbits));
  end

  assign bit_end   = tick && (os_cnt == OSW'(OS - 1));
  assign last_data = (bit_idx == IW'(nbits - 1'b1));
  assign busy      = (phase != PH_IDLE);
  assign frame_end = en && bit_end &&
                     ((phase == PH_STOP1 && !two_stop) || phase == PH_STOP2);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase   <= PH_IDLE;
      txd     <= 1'b1;
      os_cnt  <= '0;
      bit_idx <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
    end else if (load) begin
      phase   <= PH_START;
      txd     <= 1'b0;
      os_cnt  <= '0;
      bit_idx <= '0;
      sh      <= ld_word & mask;
      par_bit <= (^(ld_word & mask)) ^ par_odd;
    end else if (busy && tick) begin
      if (bit_end) begin
        os_cnt <= '0;
        case (phase)
          PH_START: begin
            phase <= PH_DATA;
            txd   <= sh[0];
          end
          PH_DATA: begin
            if (last_data) begin
              if (par_en) begin
                phase <= PH_PAR;
                txd   <= par_bit;
              end else begin
                phase <= PH_STOP1;
                txd   <= 1'b1;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              sh      <= sh >> 1;
              txd     <= sh[1];
            end
          end
          PH_PAR: begin
            phase <= PH_STOP1;
            txd   <= 1'b1;
          end
          PH_STOP1: begin
            phase <= two_stop ? PH_STOP2 : PH_IDLE;
            txd   <= 1'b1;
          end
          default: begin
            phase <= PH_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (!txd && busy));
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> (txd || busy));
  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && busy && !tick && !load) |=> $stable(txd));
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_done,
  input  logic ack,
  input  logic st_wr,
  input  logic st_val,
  input  logic empty_flag,
  input  logic ie_empty,
  input  logic ie_done,
  output logic done_flag,
  output logic irq_empty,
  output logic irq_done
);
  always_ff @(posedge clk) begin
    if (rst)                          done_flag <= 1'b0;
    else if (set_done)                done_flag <= 1'b1;
    else if (ack || (st_wr && !st_val)) done_flag <= 1'b0;
  end

  assign irq_empty = empty_flag && ie_empty;
  assign irq_done  = done_flag && ie_done;

  // R10
  ack_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_done) |=> !done_flag);
  // R8
  st_one_keeps_done_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && st_val && !ack && done_flag) |=> done_flag);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_MAX = 9,
  parameter int OS_RATE  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          baud_tick,
  input  logic                          tx_en,
  input  logic [$clog2(DATA_MAX+1)-1:0] cfg_nbits,
  input  logic                          cfg_par_en,
  input  logic                          cfg_par_odd,
  input  logic                          cfg_two_stop,
  input  logic                          tx_bit8,
  input  logic                          wr_data,
  input  logic [DATA_MAX-2:0]           wr_byte,
  input  logic                          st_wr,
  input  logic                          st_empty_val,
  input  logic                          st_done_val,
  input  logic                          done_ack,
  input  logic                          ie_empty,
  input  logic                          ie_done,
  output logic                          txd,
  output logic                          empty_flag,
  output logic                          done_flag,
  output logic                          irq_empty,
  output logic                          irq_done
);
  logic                buf_full;
  logic [DATA_MAX-1:0] buf_word;
  logic                busy;
  logic                frame_end;
  logic                load;
  logic                set_done;

  assign load     = tx_en && buf_full && (!busy || frame_end);
  assign set_done = frame_end && !buf_full;

  uart_tx_holdbuf #(.DW(DATA_MAX)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .en         (tx_en),
    .wr         (wr_data),
    .wr_word    ({tx_bit8, wr_byte}),
    .take       (load),
    .st_wr      (st_wr),
    .st_val     (st_empty_val),
    .full       (buf_full),
    .word       (buf_word),
    .empty_flag (empty_flag)
  );

  uart_tx_shifter #(.DMAX(DATA_MAX), .OS(OS_RATE)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .tick      (baud_tick),
    .load      (load),
    .ld_word   (buf_word),
    .nbits     (cfg_nbits),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .two_stop  (cfg_two_stop),
    .txd       (txd),
    .busy      (busy),
    .frame_end (frame_end)
  );

  uart_tx_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_done   (set_done),
    .ack        (done_ack),
    .st_wr      (st_wr),
    .st_val     (st_done_val),
    .empty_flag (empty_flag),
    .ie_empty   (ie_empty),
    .ie_done    (ie_done),
    .done_flag  (done_flag),
    .irq_empty  (irq_empty),
    .irq_done   (irq_done)
  );

  // R12
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (txd && empty_flag));
  // R9
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (!buf_full && !busy));
  // R6
  refill_gapless_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && frame_end && buf_full) |=> (!txd && busy));
endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] cfg_nbits = 4'd8;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       tx_bit8 = 1'b0, wr_data = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       st_wr = 1'b0, st_empty_val = 1'b1, st_done_val = 1'b1;
  logic       done_ack = 1'b0, ie_empty = 1'b0, ie_done = 1'b0;
  logic       txd, empty_flag, done_flag, irq_empty, irq_done;

  int n_chk = 0, n_fail = 0, cyc = 0, div = 1;
  int g_nb = 8, g_pe = 0, g_po = 0, g_ts = 0;
  logic [15:0] mon_word [0:255];
  int          mon_start [0:255];
  int          mon_n = 0;
  bit          done_print = 0;

  always #2.5 clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
    .cfg_nbits(cfg_nbits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .tx_bit8(tx_bit8), .wr_data(wr_data),
    .wr_byte(wr_byte), .st_wr(st_wr), .st_empty_val(st_empty_val),
    .st_done_val(st_done_val), .done_ack(done_ack), .ie_empty(ie_empty),
    .ie_done(ie_done), .txd(txd), .empty_flag(empty_flag),
    .done_flag(done_flag), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tc++;
      baud_tick = ((tc % div) == 0);
    end
  end

  // serial decoder: samples each bit in its middle
  initial begin
    logic [15:0] w;
    int len;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        mon_start[mon_n] = cyc;
        len = 2 + g_nb + g_pe + g_ts;
        w = '0;
        repeat (8 * div) @(negedge clk);
        w[0] = txd;
        for (int k = 1; k < len; k++) begin
          repeat (16 * div) @(negedge clk);
          w[k] = txd;
        end
        mon_word[mon_n] = w;
        mon_n++;
      end
    end
  end

  function automatic logic [15:0] exp_frame(logic [8:0] d);
    logic [15:0] f;
    logic p;
    int ix;
    f = '0;
    p = 1'b0;
    for (int i = 0; i < g_nb; i++) begin
      f[1 + i] = d[i];
      p = p ^ d[i];
    end
    ix = g_nb + 1;
    if (g_pe != 0) begin
      f[ix] = p ^ (g_po != 0);
      ix++;
    end
    f[ix] = 1'b1;
    if (g_ts != 0) f[ix + 1] = 1'b1;
    return f;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_print) begin
      done_print = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  endtask

  task automatic set_cfg(int nb, int pe, int po, int ts);
    g_nb = nb; g_pe = pe; g_po = po; g_ts = ts;
    cfg_nbits = 4'(nb);
    cfg_par_en = (pe != 0);
    cfg_par_odd = (po != 0);
    cfg_two_stop = (ts != 0);
  endtask

  task automatic send(logic [8:0] d);
    @(negedge clk);
    tx_bit8 = d[8];
    wr_byte = d[7:0];
    wr_data = 1'b1;
    @(negedge clk);
    wr_data = 1'b0;
  endtask

  task automatic st_write(logic ev, logic dv);
    @(negedge clk);
    st_wr = 1'b1; st_empty_val = ev; st_done_val = dv;
    @(negedge clk);
    st_wr = 1'b0; st_empty_val = 1'b1; st_done_val = 1'b1;
  endtask

  task automatic send_wait(logic [8:0] d, string tag);
    int n0;
    n0 = mon_n;
    send(d);
    wait (mon_n == n0 + 1);
    repeat (16 * div) @(negedge clk);
    chk(tag, 32'(mon_word[n0]), 32'(exp_frame(d)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int n0, lowc;
    logic [8:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 txd", 32'(txd), 1);
    chk("R1 empty", 32'(empty_flag), 1);
    chk("R1 done", 32'(done_flag), 0);
    chk("R1 irq_empty", 32'(irq_empty), 0);
    chk("R1 irq_done", 32'(irq_done), 0);
    tx_en = 1'b1;
    ie_empty = 1'b1;
    @(negedge clk);
    chk("R11 irq_empty on", 32'(irq_empty), 1);
    ie_empty = 1'b0;
    @(negedge clk);
    chk("R11 irq_empty masked", 32'(irq_empty), 0);
    ie_empty = 1'b1;
    st_write(1'b1, 1'b1);
    chk("R8 empty write one", 32'(empty_flag), 1);
    chk("R8 done write one", 32'(done_flag), 0);
    st_write(1'b0, 1'b1);
    chk("R8 empty write zero", 32'(empty_flag), 0);
    chk("R11 irq_empty follows", 32'(irq_empty), 0);
    st_write(1'b1, 1'b1);
    chk("R8 empty stays clear", 32'(empty_flag), 0);

    // R2 R3 sweep
    for (int nb = 5; nb <= 9; nb++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++)
          for (int k = 0; k < 2; k++) begin
            set_cfg(nb, (pm != 0) ? 1 : 0, (pm == 2) ? 1 : 0, ts);
            d = 9'((nb * 37 + pm * 11 + ts * 5 + k * 421) ^ (k * 9'h1FF));
            send_wait(d, $sformatf("R2 R3 frame nb=%0d par=%0d stop=%0d", nb, pm, ts + 1));
          end
    chk("R7 empty after frames", 32'(empty_flag), 1);

    // R4: ninth bit captured at write
    set_cfg(9, 1, 0, 0);
    n0 = mon_n;
    d = 9'h15A;
    send(d);
    tx_bit8 = 1'b0;
    wait (mon_n == n0 + 1);
    repeat (16) @(negedge clk);
    chk("R4 ninth bit captured", 32'(mon_word[n0]), 32'(exp_frame(d)));

    // R5: tick every third cycle
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    chk("R10 ack clears done", 32'(done_flag), 0);
    div = 3;
    set_cfg(8, 0, 0, 0);
    repeat (6) @(negedge clk);
    n0 = mon_n;
    d = 9'h0F1;
    send(d);
    while (txd) @(negedge clk);
    lowc = 0;
    while (!txd) begin
      lowc++;
      @(negedge clk);
    end
    chk("R5 start bit cycles 46..48", 32'((lowc >= 46 && lowc <= 48) ? 1 : 0), 1);
    wait (mon_n == n0 + 1);
    repeat (48) @(negedge clk);
    chk("R5 slow tick frame", 32'(mon_word[n0]), 32'(exp_frame(d)));
    div = 1;
    repeat (4) @(negedge clk);

    // R9 R10 R11 done flag
    chk("R9 done after frame", 32'(done_flag), 1);
    ie_done = 1'b1;
    @(negedge clk);
    chk("R11 irq_done on", 32'(irq_done), 1);
    ie_done = 1'b0;
    @(negedge clk);
    chk("R11 irq_done masked", 32'(irq_done), 0);
    st_write(1'b1, 1'b1);
    chk("R8 done write one", 32'(done_flag), 1);
    st_write(1'b1, 1'b0);
    chk("R8 done write zero", 32'(done_flag), 0);

    // R6 R7 R9 back to back
    set_cfg(7, 1, 1, 1);
    n0 = mon_n;
    send(9'h05C);
    repeat (3) @(negedge clk);
    send(9'h023);
    chk("R7 empty cleared by write", 32'(empty_flag), 0);
    wait (mon_n == n0 + 1);
    repeat (16) @(negedge clk);
    chk("R9 done low between frames", 32'(done_flag), 0);
    chk("R7 empty set on move", 32'(empty_flag), 1);
    wait (mon_n == n0 + 2);
    repeat (16) @(negedge clk);
    chk("R6 frame A", 32'(mon_word[n0]), 32'(exp_frame(9'h05C)));
    chk("R6 frame B", 32'(mon_word[n0 + 1]), 32'(exp_frame(9'h023)));
    chk("R6 start spacing", 32'(mon_start[n0 + 1] - mon_start[n0]), 32'(16 * (2 + 7 + 1 + 1)));
    chk("R9 done after last", 32'(done_flag), 1);
    st_write(1'b1, 1'b0);

    // R12 abort
    set_cfg(8, 0, 0, 0);
    send(9'h055);
    repeat (40) @(negedge clk);
    send(9'h0AA);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R12 txd idle on abort", 32'(txd), 1);
    chk("R12 empty on abort", 32'(empty_flag), 1);
    send(9'h000);
    @(negedge clk);
    tx_en = 1'b1;
    lowc = 0;
    repeat (400) begin
      @(negedge clk);
      if (!txd) lowc++;
    end
    chk("R12 no frame after abort", 32'(lowc), 0);
    chk("R12 done not set by abort", 32'(done_flag), 0);
    summary();
  end
endmodule